// File: doc/BRIEF.md
# Platform Interrupt Controller Register Core

This block is the register file and arbitration core of a platform-level interrupt controller. It has level-sensitive source inputs and a small number of interrupt targets (contexts). Software sees a 32-bit register space with four regions. One region holds a priority per source. One holds a read-only view of the pending bits. One holds an enable bitmap per context. The last holds a threshold and a claim/complete register per context. Each context has its own selector. The selector picks the best eligible source and drives that context's interrupt line.

A handler reads its context's claim register to take ownership of the best source. That read returns the source ID and, in the same access, clears the source's pending bit and marks it as in service. While in service, the source cannot be selected again. The handler releases it by writing the same ID back to the claim register. Priority and threshold writes pass through a legality filter that depends on the parameter `MAX_PRIO`.

The bus is a single-port request interface. Every request is acknowledged one cycle later, and read data arrives with that acknowledge. Source ID 0 is reserved and never becomes pending.

Top module: `intc_core`

## Requirements
- R1: The priority of source `id` (1..NUM_SRC-1) lives in the word at byte address PRIO_BASE + 4*(id-1). A read returns the stored value.
- R2: When MAX_PRIO+1 is a power of two, a priority or threshold write stores the written value modulo MAX_PRIO+1. Otherwise a write whose value exceeds MAX_PRIO leaves the register unchanged, and a legal value is stored as written.
- R3: Pending word k at PEND_BASE + 4*k holds source `id` = 32*k + b in bit b. Writes to the pending region have no effect.
- R4: Enable word w of context c is at EN_BASE + c*EN_STRIDE + 4*w, with source 32*w + b in bit b. Words with w >= ceil(NUM_SRC/32) read 0 and ignore writes.
- R5: In context c's window at CTX_BASE + c*CTX_STRIDE, offset 0 is the threshold and offset 4 is claim/complete. Every other offset reads 0 and ignores writes.
- R6: A claim read returns the pending, enabled, not-in-service source with the highest priority, provided that priority is strictly greater than the context threshold. On equal priorities it returns the lowest ID. If no source qualifies it returns 0.
- R7: A claim read that returns a nonzero ID clears that source's pending bit and marks it in service. A source in service is never selected by any context until it is completed.
- R8: Writing a value below NUM_SRC to a claim/complete register takes that source out of service. Larger values have no effect.
- R9: A change of level on a source input sets its pending bit to the new level. On the same edge, a claim of that source takes precedence.
- R10: irq_o[c] is high exactly when a claim read of context c would return a nonzero ID.
- R11: Every request is acknowledged by rvalid_o one cycle later. A read of an address outside the four regions returns 0.
- R12: Reset clears all priorities, thresholds, enables, pending bits and in-service bits, and drives every irq_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level-sensitive source inputs, bit 0 unused |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | Request is a write when high |
| addr_i | input | AW | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Acknowledge, one cycle after req_i |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
The assertions assume the following about the inputs: source inputs are already synchronous to clk_i, requests carry word-aligned addresses, and there is at most one request per cycle. Under those assumptions, every claim and complete is a single access whose effect can be checked on the next edge. The stimulus changes sources and bus signals only on the falling clock edge, always uses aligned addresses, and leaves an idle cycle between requests. Source levels change only while the bus is idle. The same-edge case of a source change and a claim is therefore covered by the assertions rather than by a directed check.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // True when a write of v to a priority-class register is accepted
  function automatic logic warl_ok(input int unsigned max_p, input logic [31:0] v);
    if (((max_p + 1) & max_p) == 0) return 1'b1;
    return v <= max_p;
  endfunction

  // Value stored for an accepted write
  function automatic logic [31:0] warl_val(input int unsigned max_p, input logic [31:0] v);
    if (((max_p + 1) & max_p) == 0) return v & max_p;
    return v;
  endfunction

endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned IDW     = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               claim_en_i,
  input  logic [IDW-1:0]     claim_id_i,
  input  logic               cmpl_en_i,
  input  logic [IDW-1:0]     cmpl_id_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] clm_o
);

  logic [NUM_SRC-1:0] src_q, pend_q, clm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
      clm_q  <= '0;
    end else begin
      src_q <= src_i;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (src_i[i] != src_q[i]) pend_q[i] <= src_i[i] && (i != 0);
        // claim wins over a same-edge level change
        if (claim_en_i && claim_id_i == IDW'(i)) begin
          pend_q[i] <= 1'b0;
          clm_q[i]  <= 1'b1;
        end
        if (cmpl_en_i && cmpl_id_i == IDW'(i)) clm_q[i] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;
  assign clm_o  = clm_q;

  assert_claim_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_en_i |=> clm_q[$past(claim_id_i)] && !pend_q[$past(claim_id_i)]);

  assert_complete_frees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_en_i |=> !clm_q[$past(cmpl_id_i)]);

endmodule

// File: rtl/intc_claim_sel.sv
module intc_claim_sel #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned IDW     = 6,
  parameter int unsigned PW      = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SRC-1:0]          pend_i,
  input  logic [NUM_SRC-1:0]          clm_i,
  input  logic [NUM_SRC-1:0]          en_i,
  input  logic [NUM_SRC-1:0][PW-1:0]  prio_i,
  input  logic [PW-1:0]               thr_i,
  output logic [IDW-1:0]              id_o,
  output logic                        irq_o
);

  logic [IDW-1:0] best_id;
  logic [PW-1:0]  best_p;

  // ascending scan with strict compare: ties go to the lowest ID
  always_comb begin
    best_id = '0;
    best_p  = thr_i;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && !clm_i[i] && en_i[i] && prio_i[i] > best_p) begin
        best_id = IDW'(i);
        best_p  = prio_i[i];
      end
    end
  end

  assign id_o  = best_id;
  assign irq_o = best_id != '0;

  assert_pick_eligible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_i[id_o] && !clm_i[id_o] && en_i[id_o] && prio_i[id_o] > thr_i);

endmodule

// File: rtl/intc_core.sv
module intc_core import intc_pkg::*; #(
  parameter int unsigned NUM_SRC    = 64,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned MAX_PRIO   = 7,
  parameter int unsigned AW         = 16,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned EN_BASE    = 32'h2000,
  parameter int unsigned EN_STRIDE  = 32'h80,
  parameter int unsigned CTX_BASE   = 32'h4000,
  parameter int unsigned CTX_STRIDE = 32'h100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  output logic               rvalid_o,
  output logic [31:0]        rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);

  localparam int unsigned NW        = (NUM_SRC + 31) / 32;
  localparam int unsigned SRCP      = NW * 32;
  localparam int unsigned IDW       = $clog2(NUM_SRC);
  localparam int unsigned PW        = $clog2(MAX_PRIO + 1);
  localparam int unsigned CW        = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int unsigned PRIO_SPAN = (NUM_SRC - 1) * 4;
  localparam int unsigned PEND_SPAN = NW * 4;
  localparam int unsigned EN_SPAN   = NUM_CTX * EN_STRIDE;
  localparam int unsigned CTX_SPAN  = NUM_CTX * CTX_STRIDE;
  localparam int unsigned EN_SH     = $clog2(EN_STRIDE);
  localparam int unsigned CTX_SH    = $clog2(CTX_STRIDE);

  logic [NUM_SRC-1:0][PW-1:0] prio_q;
  logic [NUM_CTX-1:0][SRCP-1:0] en_q;
  logic [NUM_CTX-1:0][PW-1:0] thr_q;
  logic [NUM_SRC-1:0] pend, clm;
  logic [SRCP-1:0] pend_pad;
  logic [NUM_CTX-1:0][IDW-1:0] sel_id;

  // decode
  logic [31:0] a, o_prio, o_pend, o_en, o_ctx, pend_word, en_word, ctx_sub;
  logic hit_prio, hit_pend, hit_en, hit_ctx;
  logic [IDW-1:0] prio_idx;
  logic [CW-1:0]  en_ctx, ctx_idx;

  assign a         = 32'(addr_i);
  assign o_prio    = a - PRIO_BASE;
  assign o_pend    = a - PEND_BASE;
  assign o_en      = a - EN_BASE;
  assign o_ctx     = a - CTX_BASE;
  assign hit_prio  = a >= PRIO_BASE && o_prio < PRIO_SPAN;
  assign hit_pend  = a >= PEND_BASE && o_pend < PEND_SPAN;
  assign hit_en    = a >= EN_BASE   && o_en   < EN_SPAN;
  assign hit_ctx   = a >= CTX_BASE  && o_ctx  < CTX_SPAN;
  assign prio_idx  = IDW'((o_prio >> 2) + 1);
  assign pend_word = o_pend >> 2;
  assign en_ctx    = CW'(o_en >> EN_SH);
  assign en_word   = (o_en & (EN_STRIDE - 1)) >> 2;
  assign ctx_idx   = CW'(o_ctx >> CTX_SH);
  assign ctx_sub   = o_ctx & (CTX_STRIDE - 1);
  assign pend_pad  = SRCP'(pend);

  logic rd_op, wr_op, claim_en, cmpl_en;
  assign rd_op    = req_i && !we_i;
  assign wr_op    = req_i && we_i;
  assign claim_en = rd_op && hit_ctx && ctx_sub == 4 && sel_id[ctx_idx] != '0;
  assign cmpl_en  = wr_op && hit_ctx && ctx_sub == 4 && wdata_i < NUM_SRC;

  logic [31:0] rd;
  always_comb begin
    rd = '0;
    if (hit_prio) rd = 32'(prio_q[prio_idx]);
    else if (hit_pend) rd = pend_pad[pend_word*32 +: 32];
    else if (hit_en) begin
      if (en_word < NW) rd = en_q[en_ctx][en_word*32 +: 32];
    end else if (hit_ctx) begin
      if (ctx_sub == 0) rd = 32'(thr_q[ctx_idx]);
      else if (ctx_sub == 4) rd = 32'(sel_id[ctx_idx]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q   <= '0;
      en_q     <= '0;
      thr_q    <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i;
      rdata_o  <= rd_op ? rd : '0;
      if (wr_op) begin
        if (hit_prio && warl_ok(MAX_PRIO, wdata_i))
          prio_q[prio_idx] <= PW'(warl_val(MAX_PRIO, wdata_i));
        if (hit_en && en_word < NW)
          en_q[en_ctx][en_word*32 +: 32] <= wdata_i;
        if (hit_ctx && ctx_sub == 0 && warl_ok(MAX_PRIO, wdata_i))
          thr_q[ctx_idx] <= PW'(warl_val(MAX_PRIO, wdata_i));
      end
    end
  end

  intc_pending #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .claim_en_i (claim_en),
    .claim_id_i (sel_id[ctx_idx]),
    .cmpl_en_i  (cmpl_en),
    .cmpl_id_i  (IDW'(wdata_i)),
    .pend_o     (pend),
    .clm_o      (clm)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    intc_claim_sel #(.NUM_SRC(NUM_SRC), .IDW(IDW), .PW(PW)) u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (pend),
      .clm_i  (clm),
      .en_i   (en_q[c][NUM_SRC-1:0]),
      .prio_i (prio_q),
      .thr_i  (thr_q[c]),
      .id_o   (sel_id[c]),
      .irq_o  (irq_o[c])
    );
  end

  assert_ack_next_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);

  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_op && !(hit_prio || hit_pend || hit_en || hit_ctx) |=> rdata_o == '0);

  assert_irq_claim_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_op && hit_ctx && ctx_sub == 4 && irq_o[ctx_idx] |=> rdata_o != '0);

endmodule

// File: tb/tb_intc_core.sv
module tb_intc_core;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] src = '0;
  logic req_a = 1'b0, req_b = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid_a, rvalid_b;
  logic [31:0] rdata_a, rdata_b;
  logic [1:0] irq_a, irq_b;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_core dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req_a), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid_a), .rdata_o(rdata_a), .irq_o(irq_a)
  );

  // non-power-of-two priority count
  intc_core #(.MAX_PRIO(5)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req_b), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid_b), .rdata_o(rdata_b), .irq_o(irq_b)
  );

  typedef struct packed {
    logic        w;
    logic [15:0] ad;
    logic [31:0] wd;
    logic        ck;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0010, 32'd3,      1'b0, 32'd0,      8'd1},  // R1 source 5
    '{1'b0, 16'h0010, 32'd0,      1'b1, 32'd3,      8'd1},  // R1
    '{1'b1, 16'h0010, 32'd12,     1'b0, 32'd0,      8'd2},  // R2 12 mod 8
    '{1'b0, 16'h0010, 32'd0,      1'b1, 32'd4,      8'd2},  // R2
    '{1'b1, 16'h009C, 32'd6,      1'b0, 32'd0,      8'd1},  // R1 source 40
    '{1'b0, 16'h009C, 32'd0,      1'b1, 32'd6,      8'd1},
    '{1'b1, 16'h4000, 32'd9,      1'b0, 32'd0,      8'd2},  // R2 threshold 9 mod 8
    '{1'b0, 16'h4000, 32'd0,      1'b1, 32'd1,      8'd2},
    '{1'b1, 16'h2000, 32'h20,     1'b0, 32'd0,      8'd4},  // R4 enable 5 ctx0
    '{1'b0, 16'h2000, 32'd0,      1'b1, 32'h20,     8'd4},
    '{1'b1, 16'h2004, 32'h100,    1'b0, 32'd0,      8'd4},  // R4 enable 40 ctx0
    '{1'b0, 16'h2004, 32'd0,      1'b1, 32'h100,    8'd4},
    '{1'b1, 16'h2008, 32'hFFFF,   1'b0, 32'd0,      8'd4},  // R4 beyond bitmap
    '{1'b0, 16'h2008, 32'd0,      1'b1, 32'd0,      8'd4},
    '{1'b1, 16'h4008, 32'd5,      1'b0, 32'd0,      8'd5},  // R5 bad offset
    '{1'b0, 16'h4008, 32'd0,      1'b1, 32'd0,      8'd5},
    '{1'b0, 16'h3000, 32'd0,      1'b1, 32'd0,      8'd11}, // R11 unmapped
    '{1'b1, 16'h2080, 32'h20,     1'b0, 32'd0,      8'd4},  // R4 enable 5 ctx1
    '{1'b0, 16'h2080, 32'd0,      1'b1, 32'h20,     8'd4},
    '{1'b1, 16'h4100, 32'd4,      1'b0, 32'd0,      8'd5},  // R5 threshold ctx1
    '{1'b0, 16'h4100, 32'd0,      1'b1, 32'd4,      8'd5},
    '{1'b0, 16'h1000, 32'd0,      1'b1, 32'd0,      8'd3}   // R3 nothing pending
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic bus(input bit b, input bit w, input logic [15:0] ad,
                     input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    we = w; addr = ad; wdata = wd;
    if (b) req_b = 1'b1; else req_a = 1'b1;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0;
    chk("R11 ack", b ? 32'(rvalid_b) : 32'(rvalid_a), 32'd1);
    rd = b ? rdata_b : rdata_a;
  endtask

  task automatic wr(input logic [15:0] ad, input logic [31:0] wd);
    logic [31:0] d;
    bus(1'b0, 1'b1, ad, wd, d);
  endtask

  task automatic rd_chk(input string rq, input logic [15:0] ad, input logic [31:0] exp);
    logic [31:0] d;
    bus(1'b0, 1'b0, ad, 32'd0, d);
    chk(rq, d, exp);
  endtask

  task automatic set_src(input int id, input bit v);
    @(negedge clk);
    src[id] = v;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 irq", 32'(irq_a), 32'd0);
    rd_chk("R12 claim", 16'h4004, 32'd0);
    rd_chk("R12 prio", 16'h0010, 32'd0);

    for (int i = 0; i < NV; i++) begin
      bus(1'b0, VEC[i].w, VEC[i].ad, VEC[i].wd, d);
      if (VEC[i].ck) chk($sformatf("R%0d vec%0d", VEC[i].rq, i), d, VEC[i].ex);
    end

    set_src(5, 1'b1);
    set_src(40, 1'b1);
    rd_chk("R9 pend w0", 16'h1000, 32'h20);
    rd_chk("R3 pend w1", 16'h1004, 32'h100);
    chk("R10 irq", 32'(irq_a), 32'd1);
    wr(16'h1000, 32'd0);
    rd_chk("R3 write ignored", 16'h1000, 32'h20);

    rd_chk("R6 highest", 16'h4004, 32'd40);
    rd_chk("R7 pend cleared", 16'h1004, 32'd0);
    rd_chk("R6 next", 16'h4004, 32'd5);
    rd_chk("R7 none left", 16'h4004, 32'd0);
    chk("R10 irq low", 32'(irq_a), 32'd0);

    set_src(5, 1'b0);
    set_src(5, 1'b1);
    rd_chk("R9 repend", 16'h1000, 32'h20);
    rd_chk("R7 masked", 16'h4004, 32'd0);
    chk("R7 irq masked", 32'(irq_a), 32'd0);

    wr(16'h4004, 32'd64);
    rd_chk("R8 big ignored", 16'h4004, 32'd0);
    wr(16'h4004, 32'd5);
    chk("R10 irq after complete", 32'(irq_a), 32'd1);
    rd_chk("R8 released", 16'h4004, 32'd5);

    // tie at priority 4
    wr(16'h009C, 32'd4);
    wr(16'h4004, 32'd40);
    wr(16'h4004, 32'd5);
    set_src(40, 1'b0);
    set_src(40, 1'b1);
    set_src(5, 1'b0);
    set_src(5, 1'b1);
    rd_chk("R6 strict thr", 16'h4104, 32'd0);
    rd_chk("R6 tie low id", 16'h4004, 32'd5);
    rd_chk("R6 tie second", 16'h4004, 32'd40);

    wr(16'h4100, 32'd3);
    wr(16'h4004, 32'd5);
    set_src(5, 1'b0);
    set_src(5, 1'b1);
    chk("R10 both ctx", 32'(irq_a), 32'd3);
    rd_chk("R6 ctx1 claim", 16'h4104, 32'd5);
    chk("R7 cross ctx mask", 32'(irq_a), 32'd0);

    wr(16'h4004, 32'd5);
    set_src(5, 1'b0);
    set_src(5, 1'b1);
    rd_chk("R9 rise", 16'h1000, 32'h20);
    set_src(5, 1'b0);
    rd_chk("R9 fall", 16'h1000, 32'd0);

    bus(1'b1, 1'b1, 16'h0000, 32'd6, d);
    bus(1'b1, 1'b0, 16'h0000, 32'd0, d);
    chk("R2 dropped", d, 32'd0);
    bus(1'b1, 1'b1, 16'h0000, 32'd5, d);
    bus(1'b1, 1'b0, 16'h0000, 32'd0, d);
    chk("R2 legal", d, 32'd5);
    bus(1'b1, 1'b1, 16'h4000, 32'd9, d);
    bus(1'b1, 1'b0, 16'h4000, 32'd0, d);
    chk("R2 thr dropped", d, 32'd0);

    set_src(5, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 irq reset", 32'(irq_a), 32'd0);
    src = '0;
    rst_n = 1'b1;
    rd_chk("R12 prio reset", 16'h009C, 32'd0);
    rd_chk("R12 en reset", 16'h2000, 32'd0);
    rd_chk("R12 thr reset", 16'h4000, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule